// File: doc/BRIEF.md
# Vector Doubleword Multiply-Sum Unit

This block is the multiply-sum datapath of a 128-bit vector unit. Each 128-bit operand is treated as two unsigned 64-bit doublewords. Doubleword 0 is the upper half and doubleword 1 is the lower half. The unit forms the full 128-bit product of the upper lanes of A and B and the full 128-bit product of the lower lanes. It adds both products to the 128-bit addend C.

A 6-bit minor opcode field chooses what the unit returns:

- The wrap-around operation returns the low 128 bits of the three-term sum.
- The carry operation returns only the part of that sum that overflows past bit 127. This value is 0 to 3. It sits in the low bits of doubleword 1, and doubleword 0 is zero.

Any other opcode is flagged as illegal and gives no result. The unit is a three-stage pipeline: multiply, lane reduction, final add. Issue uses a valid strobe, there is no backpressure, and one operation can be accepted every cycle.

Top module: `vdw_msum_unit`

## Requirements
- R1: With opcode 35, `result` equals (C + A[127:64]*B[127:64] + A[63:0]*B[63:0]) mod 2^128. Bits 127:64 hold the upper half of that sum and bits 63:0 hold the lower half.
- R2: With opcode 23, `result[63:0]` equals floor((C + A[127:64]*B[127:64] + A[63:0]*B[63:0]) / 2^128), which lies between 0 and 3. Bits 127:64 are zero.
- R3: Opcode 35 selects the wrap-around operation and opcode 23 selects the carry operation. The same operands issued under each opcode give the R1 and R2 results respectively.
- R4: An issue with any opcode other than 35 or 23 raises `illegalOp` for one cycle, three cycles after the issue, with `outValid` low in that cycle.
- R5: A legal issue with `inValid` high at a rising edge shows `outValid` high for exactly one cycle, three rising edges later. Issues on consecutive cycles produce results on consecutive cycles, in issue order.
- R6: While `rst` is high, and afterwards until a new issue has travelled through the pipeline, `outValid` and `illegalOp` stay low, whatever `inValid` did during reset.
- R7: `result` changes only in a cycle where `outValid` is high. An illegal issue or an idle cycle leaves the last result in place.
- R8: No intermediate sum truncates. All-ones operands give the exact results of R1 and R2, which for the carry operation is the value 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the pipeline valid bits |
| inValid | input | 1 | Issue strobe for the operands and opcode |
| minorOp | input | 6 | Minor opcode: 35 for wrap-around, 23 for carry |
| srcA | input | 128 | Multiplicand vector, two 64-bit lanes |
| srcB | input | 128 | Multiplier vector, two 64-bit lanes |
| srcC | input | 128 | 128-bit addend |
| outValid | output | 1 | Result valid, three cycles after a legal issue |
| illegalOp | output | 1 | Illegal opcode flag, three cycles after the issue |
| result | output | 128 | Wrap-around sum or carry value |

## Verification
The latency and flag properties assume that `minorOp` is meaningful only in cycles where `inValid` is high. They also assume that the inputs are stable across each sampling edge. The bench drives every input on the falling edge and marks each idle cycle with `inValid` low.

The carry-range property assumes that an issue keeps its opcode with it through the pipeline. The bench tests this by mixing both opcodes and illegal codes in back-to-back streams. It also holds `inValid` high during reset, so that a pipeline which was not cleared would show up.

// File: rtl/vmsum_pkg.sv
package vmsum_pkg;
  localparam int unsigned XO_WIDTH = 6;
  localparam logic [XO_WIDTH-1:0] XO_WRAP  = 6'd35;
  localparam logic [XO_WIDTH-1:0] XO_CARRY = 6'd23;
  localparam int unsigned PIPE_DEPTH = 3;

  // strobes from the control to the datapath
  typedef struct packed {
    logic ldMul;
    logic ldReduce;
    logic ldFinal;
    logic carrySel;
  } dpCtrl_t;
endpackage

// File: rtl/vmsum_ctrl.sv
module vmsum_ctrl
  import vmsum_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [XO_WIDTH-1:0] minorOp,
  output dpCtrl_t             ctrl,
  output logic                outValid,
  output logic                illegalOp
);
  logic isWrap, isCarry, isLegal;
  logic [PIPE_DEPTH-1:0] vldQ;
  logic [PIPE_DEPTH-1:0] illQ;
  logic [PIPE_DEPTH-2:0] carryQ;

  always_comb begin
    isWrap  = (minorOp == XO_WRAP);
    isCarry = (minorOp == XO_CARRY);
    isLegal = isWrap | isCarry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vldQ <= '0;
      illQ <= '0;
    end else begin
      vldQ <= {vldQ[PIPE_DEPTH-2:0], inValid & isLegal};
      illQ <= {illQ[PIPE_DEPTH-2:0], inValid & ~isLegal};
    end
  end

  // opcode kind rides with the data, no reset needed
  always_ff @(posedge clk) begin
    carryQ <= {carryQ[PIPE_DEPTH-3:0], isCarry};
  end

  always_comb begin
    ctrl.ldMul    = inValid & isLegal;
    ctrl.ldReduce = vldQ[0];
    ctrl.ldFinal  = vldQ[1];
    ctrl.carrySel = carryQ[PIPE_DEPTH-2];
    outValid      = vldQ[PIPE_DEPTH-1];
    illegalOp     = illQ[PIPE_DEPTH-1];
  end
endmodule

// File: rtl/vmsum_dp.sv
module vmsum_dp
  import vmsum_pkg::*;
#(
  parameter int unsigned LANE_W = 64
) (
  input  logic                  clk,
  input  dpCtrl_t               ctrl,
  input  logic [2*LANE_W-1:0]   srcA,
  input  logic [2*LANE_W-1:0]   srcB,
  input  logic [2*LANE_W-1:0]   srcC,
  output logic [2*LANE_W-1:0]   result
);
  localparam int unsigned VEC_W  = 2 * LANE_W;
  localparam int unsigned PROD_W = 2 * LANE_W;
  localparam int unsigned SUM_W  = LANE_W + 2;
  localparam int unsigned LANES  = 2;

  logic [LANES-1:0][PROD_W-1:0] prodQ;
  logic [VEC_W-1:0]             addQ;
  logic [SUM_W-1:0]             loSum, hiSum, loSumQ, hiSumQ, hiTotal;

  // stage 1: one full-width product per lane (lane 0 is the upper half)
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [PROD_W-1:0] aExt, bExt;
    always_comb begin
      aExt = PROD_W'(srcA[VEC_W-1-g*LANE_W -: LANE_W]);
      bExt = PROD_W'(srcB[VEC_W-1-g*LANE_W -: LANE_W]);
    end
    always_ff @(posedge clk) begin
      if (ctrl.ldMul) prodQ[g] <= aExt * bExt;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.ldMul) addQ <= srcC;
  end

  // stage 2: reduce the three low halves and the three high halves
  always_comb begin
    loSum = SUM_W'(addQ[LANE_W-1:0]) + SUM_W'(prodQ[0][LANE_W-1:0])
          + SUM_W'(prodQ[1][LANE_W-1:0]);
    hiSum = SUM_W'(addQ[VEC_W-1:LANE_W]) + SUM_W'(prodQ[0][PROD_W-1:LANE_W])
          + SUM_W'(prodQ[1][PROD_W-1:LANE_W]);
  end

  always_ff @(posedge clk) begin
    if (ctrl.ldReduce) begin
      loSumQ <= loSum;
      hiSumQ <= hiSum;
    end
  end

  // stage 3: fold the low carry into the high half
  always_comb begin
    hiTotal = hiSumQ + SUM_W'(loSumQ[SUM_W-1:LANE_W]);
  end

  always_ff @(posedge clk) begin
    if (ctrl.ldFinal) begin
      if (ctrl.carrySel)
        result <= {LANE_W'(0), LANE_W'(hiTotal[SUM_W-1:LANE_W])};
      else
        result <= {hiTotal[LANE_W-1:0], loSumQ[LANE_W-1:0]};
    end
  end
endmodule

// File: rtl/vdw_msum_unit.sv
module vdw_msum_unit
  import vmsum_pkg::*;
#(
  parameter int unsigned LANE_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [XO_WIDTH-1:0] minorOp,
  input  logic [2*LANE_W-1:0] srcA,
  input  logic [2*LANE_W-1:0] srcB,
  input  logic [2*LANE_W-1:0] srcC,
  output logic                outValid,
  output logic                illegalOp,
  output logic [2*LANE_W-1:0] result
);
  dpCtrl_t ctrl;

  vmsum_ctrl uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .minorOp(minorOp),
    .ctrl(ctrl), .outValid(outValid), .illegalOp(illegalOp)
  );

  vmsum_dp #(.LANE_W(LANE_W)) uDp (
    .clk(clk), .ctrl(ctrl), .srcA(srcA), .srcB(srcB), .srcC(srcC),
    .result(result)
  );
endmodule

// File: rtl/vmsum_chk.sv
module vmsum_chk
  import vmsum_pkg::*;
#(
  parameter int unsigned LANE_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic [XO_WIDTH-1:0] minorOp,
  input logic [2*LANE_W-1:0] srcA,
  input logic [2*LANE_W-1:0] srcB,
  input logic [2*LANE_W-1:0] srcC,
  input logic                outValid,
  input logic                illegalOp,
  input logic [2*LANE_W-1:0] result
);
  logic [1:0] sinceRst;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end
  assign warm = (sinceRst == 2'd3);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    warm |-> (outValid == $past(inValid && (minorOp == XO_WRAP || minorOp == XO_CARRY), 3))); // R5

  AST_ILLEGAL_LATENCY: assert property (@(posedge clk) disable iff (rst)
    warm |-> (illegalOp == $past(inValid && minorOp != XO_WRAP && minorOp != XO_CARRY, 3))); // R4

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(outValid && illegalOp)); // R4

  AST_CARRY_RANGE: assert property (@(posedge clk) disable iff (rst)
    (warm && outValid && $past(minorOp == XO_CARRY, 3)) |-> (result[2*LANE_W-1:2] == '0)); // R2

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 2'd0 && !outValid) |-> $stable(result)); // R7

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 2'd3) |-> (!outValid && !illegalOp)); // R6
endmodule

bind vdw_msum_unit vmsum_chk #(.LANE_W(LANE_W)) chk (.*);

// File: tb/tb_vdw_msum_unit.sv
module tb_vdw_msum_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [5:0]   minorOp = 6'd0;
  logic [127:0] srcA = '0, srcB = '0, srcC = '0;
  logic         outValid, illegalOp;
  logic [127:0] result;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    bit           ill;
    logic [127:0] expv;
    int           due;
    string        tag;
  } item_t;
  item_t sbq[$];
  logic [127:0] lastGood = '0;

  localparam logic [63:0] ONES = '1;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vdw_msum_unit dut (
    .clk(clk), .rst(rst), .inValid(inValid), .minorOp(minorOp),
    .srcA(srcA), .srcB(srcB), .srcC(srcC),
    .outValid(outValid), .illegalOp(illegalOp), .result(result)
  );

  function automatic logic [255:0] refSum(logic [127:0] a, logic [127:0] b, logic [127:0] c);
    logic [255:0] p1, p2;
    p1 = 256'(a[127:64]) * 256'(b[127:64]);
    p2 = 256'(a[63:0]) * 256'(b[63:0]);
    return 256'(c) + p1 + p2;
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", tag, act, expv, cyc);
    end
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic issue(logic [5:0] op, logic [127:0] a, logic [127:0] b, logic [127:0] c, string tag);
    item_t it;
    logic [255:0] s;
    inValid = 1'b1; minorOp = op; srcA = a; srcB = b; srcC = c;
    s = refSum(a, b, c);
    it.due = cyc + 3;
    it.tag = tag;
    if (op == 6'd35) begin it.ill = 1'b0; it.expv = s[127:0]; end
    else if (op == 6'd23) begin it.ill = 1'b0; it.expv = {64'd0, s[191:128]}; end
    else begin it.ill = 1'b1; it.expv = '0; end
    sbq.push_back(it);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle(int n);
    inValid = 1'b0;
    minorOp = $urandom;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (sbq.size() != 0 && sbq[0].due == cyc) begin
        item_t it;
        it = sbq.pop_front();
        if (it.ill) begin
          check(illegalOp === 1'b1 && outValid === 1'b0, {"R4 illegal flag ", it.tag},
                {126'd0, outValid, illegalOp}, 128'd1);
          check(result === lastGood, {"R7 result held ", it.tag}, result, lastGood);
        end else begin
          check(outValid === 1'b1 && illegalOp === 1'b0, {"R5 valid timing ", it.tag},
                {126'd0, outValid, illegalOp}, 128'd2);
          check(result === it.expv, it.tag, result, it.expv);
          lastGood = it.expv;
        end
      end else if (outValid || illegalOp) begin
        check(1'b0, "R6 unexpected output", {126'd0, outValid, illegalOp}, 128'd0);
      end else begin
        check(result === lastGood || cyc < 12, "R7 result stable when idle", result, lastGood);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, c;
    // R6: junk issues while reset is held
    inValid = 1'b1; minorOp = 6'd35;
    repeat (5) begin
      @(negedge clk);
      check(outValid === 1'b0 && illegalOp === 1'b0, "R6 flags low in reset",
            {126'd0, outValid, illegalOp}, 128'd0);
    end
    inValid = 1'b0; rst = 1'b0;
    idle(4);
    check(outValid === 1'b0 && illegalOp === 1'b0, "R6 flags low after reset",
          {126'd0, outValid, illegalOp}, 128'd0);

    // directed cases
    issue(6'd35, '0, '0, '0, "R1 zero operands");
    issue(6'd23, '0, '0, '0, "R2 zero operands");
    issue(6'd35, '1, '1, '1, "R8 R1 all ones");
    issue(6'd23, '1, '1, '1, "R8 R2 all ones carry 2");
    issue(6'd35, {ONES, 64'd0}, {ONES, 64'd0}, '0, "R1 upper lane only");
    issue(6'd35, {64'd0, ONES}, {64'd0, ONES}, 128'd5, "R1 lower lane only");
    issue(6'd23, {64'd0, ONES}, {64'd0, ONES}, '1, "R2 lower lane carry 1");
    issue(6'd23, '0, '0, '1, "R2 addend only carry 0");
    issue(6'd0, '1, '1, '1, "R4 opcode 0");
    issue(6'd63, '1, '1, '1, "R4 opcode 63");
    issue(6'd36, '1, '1, '1, "R4 opcode 36");
    idle(2);
    // R3: same operands under both opcodes
    a = rnd128(); b = rnd128(); c = rnd128();
    issue(6'd35, a, b, c, "R3 wrap select");
    issue(6'd23, a, b, c, "R3 carry select");
    issue(6'd22, a, b, c, "R4 opcode 22");
    idle(3);

    // random streams, back to back with occasional gaps and illegal codes
    for (int i = 0; i < 1100; i++) begin
      a = rnd128(); b = rnd128(); c = rnd128();
      if (i % 4 == 0) a[127:64] = ONES;
      if (i % 5 == 0) c = '1;
      issue(6'd35, a, b, c, "R1 random wrap");
      issue(6'd23, a, b, c, "R2 random carry");
      if ($urandom_range(9) == 0) issue(6'($urandom_range(63, 36)), a, b, c, "R4 random illegal");
      if ($urandom_range(7) == 0) idle($urandom_range(3, 1));
    end

    idle(6);
    check(sbq.size() == 0, "R5 all issues answered", 128'(sbq.size()), 128'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule